// File: doc/BRIEF.md
# OR-Indexed Data Memory Access Unit

This unit sits in the data path of a single-cycle machine. It forms the data-memory address for each instruction and carries out the access on a 4096-word on-chip RAM. The effective address is the bitwise OR of a 12-bit base constant from the instruction and one of eight 12-bit pointer registers. No adder is used. When a base is aligned to a power-of-two block and a pointer stays below that block size, the OR selects one entry of an array. The usual case is a 64-entry array whose base is a multiple of 64. A base of zero hands the full pointer through, which gives random access to the whole RAM.

Reads return data combinationally in the cycle they are issued. A write is captured into a one-entry pending buffer and reaches the RAM during the following cycle, overlapping the next instruction. A read of the address just written is served from that buffer. Consecutive writes are allowed: the older one commits while the newer one is captured.

The access port carries `acc_valid` and the read result carries `rd_valid`. There is no ready signal, because the unit accepts every access in every cycle and never applies back-pressure. The producer may assert `acc_valid` whenever it likes. The consumer must take `rd_data` in the cycle in which `rd_valid` is high.

Top module: `orx_mem_unit`

## Requirements
- R1: `acc_addr` equals `acc_base | ptr[acc_sel]` in the same cycle, for every bit pattern. Overlapping set bits are simply merged, with no error.
- R2: With `acc_base` zero, `acc_addr` equals the full 12-bit selected pointer, so any RAM word can be reached.
- R3: `rd_valid` is high exactly when `acc_valid` is high and `acc_write` is low (1 = write, 0 = read). `rd_data` holds the word at `acc_addr` in that same cycle.
- R4: A write of `acc_wdata` to `acc_addr` is committed to RAM in the next cycle. Any later read of that address returns it, and arrays at different aligned bases keep separate contents.
- R5: A read in the cycle right after a write to the same address returns the written data. A read there of a different address returns that address's RAM content.
- R6: Writes in consecutive cycles all take effect. A read right after two writes to one address returns the younger data.
- R7: A pointer load (`ptr_ld_en`, `ptr_ld_sel`, `ptr_ld_data`) takes effect from the next cycle. An access in the load cycle uses the prior value.
- R8: Synchronous active-high `rst` clears all pointers to zero and discards a pending write. A write issued in the cycle before a reset cycle never reaches the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_ld_en | input | 1 | Load a pointer register |
| ptr_ld_sel | input | 3 | Pointer register to load |
| ptr_ld_data | input | 12 | Value to load |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Pointer register used as index |
| acc_base | input | 12 | Base constant ORed with the index |
| acc_wdata | input | 16 | Write data |
| acc_addr | output | 12 | Effective address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |

## Verification
The hardest case to reach is a read that depends on the pending buffer rather than on the RAM. It arises in three ways: a read of the same address in the cycle after a write, two writes to one address in a row, and a reset landing in the commit cycle of a write. Reaching each needs the RAM to hold a known older value at that address first. The bench therefore fills eight 64-entry arrays with an address-derived pattern before it runs any of these cycle-exact sequences. Each sequence is then checked against both the older value and the newer one.

// File: rtl/orx_pkg.sv
package orx_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;

  function automatic logic [11:0] or_merge(input logic [11:0] base, input logic [11:0] idx);
    return base | idx;
  endfunction
endpackage

// File: rtl/orx_ptr_bank.sv
module orx_ptr_bank #(
  parameter int NPTR = 8,
  parameter int AW   = 12,
  localparam int SW  = $clog2(NPTR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [AW-1:0] ld_data,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] rd_ptr
);
  logic [AW-1:0] regs [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (ld_en && (ld_sel == SW'(g)))
        regs[g] <= ld_data;
    end
  end

  assign rd_ptr = regs[rd_sel];
endmodule

// File: rtl/orx_addr_or.sv
module orx_addr_or #(
  parameter int AW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] ea
);
  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign ea[b] = base[b] | idx[b];
  end
endmodule

// File: rtl/orx_store.sv
module orx_store #(
  parameter int AW    = 12,
  parameter int DW    = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic          pend_vld;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  logic          hit;

  always_ff @(posedge clk) begin
    if (rst)
      pend_vld <= 1'b0;
    else
      pend_vld <= wr_req;
  end

  always_ff @(posedge clk) begin
    if (wr_req) begin
      pend_addr <= addr;
      pend_data <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_vld && !rst)
      mem[pend_addr] <= pend_data;
  end

  assign hit   = pend_vld && (pend_addr == addr);
  assign rdata = hit ? pend_data : mem[addr];
endmodule

// File: rtl/orx_mem_unit.sv
module orx_mem_unit #(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int NPTR = 8,
  localparam int SW  = $clog2(NPTR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_ld_en,
  input  logic [SW-1:0] ptr_ld_sel,
  input  logic [AW-1:0] ptr_ld_data,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [SW-1:0] acc_sel,
  input  logic [AW-1:0] acc_base,
  input  logic [DW-1:0] acc_wdata,
  output logic [AW-1:0] acc_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  import orx_pkg::*;

  logic [AW-1:0] idx;
  op_e           op;

  assign op = acc_write ? OP_WR : OP_RD;

  orx_ptr_bank #(.NPTR(NPTR), .AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .ld_en(ptr_ld_en), .ld_sel(ptr_ld_sel),
    .ld_data(ptr_ld_data), .rd_sel(acc_sel), .rd_ptr(idx)
  );

  orx_addr_or #(.AW(AW)) u_or (
    .base(acc_base), .idx(idx), .ea(acc_addr)
  );

  orx_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .wr_req(acc_valid && (op == OP_WR)),
    .addr(acc_addr), .wdata(acc_wdata), .rdata(rd_data)
  );

  assign rd_valid = acc_valid && (op == OP_RD);
endmodule

// File: rtl/orx_mem_unit_chk.sv
module orx_mem_unit_chk #(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int NPTR = 8,
  localparam int SW  = $clog2(NPTR)
) (
  input logic          clk,
  input logic          rst,
  input logic          ptr_ld_en,
  input logic [SW-1:0] ptr_ld_sel,
  input logic [AW-1:0] ptr_ld_data,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [SW-1:0] acc_sel,
  input logic [AW-1:0] acc_base,
  input logic [DW-1:0] acc_wdata,
  input logic [AW-1:0] acc_addr,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data
);
  assert_base_kept_R1: assert property (@(posedge clk) disable iff (rst)
    (acc_addr & acc_base) == acc_base);

  assert_no_read_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !rd_valid);

  assert_forward_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid) && $past(acc_write) && acc_valid && !acc_write
     && (acc_addr == $past(acc_addr))) |-> (rd_data == $past(acc_wdata)));

  assert_ptr_load_R7: assert property (@(posedge clk) disable iff (rst)
    ptr_ld_en |=> ((acc_sel != $past(ptr_ld_sel)) ||
                   (acc_addr == ($past(ptr_ld_data) | acc_base))));

  assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && (acc_base == '0)) |-> (acc_addr == '0));
endmodule

bind orx_mem_unit orx_mem_unit_chk #(.AW(AW), .DW(DW), .NPTR(NPTR)) u_chk (
  .clk(clk), .rst(rst), .ptr_ld_en(ptr_ld_en), .ptr_ld_sel(ptr_ld_sel),
  .ptr_ld_data(ptr_ld_data), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_sel(acc_sel), .acc_base(acc_base), .acc_wdata(acc_wdata),
  .acc_addr(acc_addr), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/test_orx_mem_unit.sv
`timescale 1ns/1ps
module test_orx_mem_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_ld_en = 1'b0;
  logic [2:0]  ptr_ld_sel = '0;
  logic [11:0] ptr_ld_data = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic [11:0] acc_base = '0;
  logic [15:0] acc_wdata = '0;
  logic [11:0] acc_addr;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  orx_mem_unit i_orx_mem_unit (
    .clk(clk), .rst(rst), .ptr_ld_en(ptr_ld_en), .ptr_ld_sel(ptr_ld_sel),
    .ptr_ld_data(ptr_ld_data), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_base(acc_base), .acc_wdata(acc_wdata),
    .acc_addr(acc_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [15:0] dpat(input logic [11:0] a);
    return {a[3:0], a} ^ 16'hA5C3;
  endfunction

  function automatic logic [11:0] pv(input int i);
    return 12'((i * 12'h1D3 + 7) & 12'hFFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input int s, input logic [11:0] b, input logic [15:0] d);
    @(negedge clk);
    ptr_ld_en = 1'b0; acc_valid = 1'b1; acc_write = w;
    acc_sel = 3'(s); acc_base = b; acc_wdata = d;
    #1;
  endtask

  task automatic ldp(input int s, input logic [11:0] v);
    @(negedge clk);
    acc_valid = 1'b0; ptr_ld_en = 1'b1; ptr_ld_sel = 3'(s); ptr_ld_data = v;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; ptr_ld_en = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] a, b, c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: pointers clear after reset
    for (int s = 0; s < 8; s++) begin
      acc(1'b0, s, 12'h000, 16'h0);
      chk("R8 ptr reset", 32'(acc_addr), 32'h0);
    end
    idle();
    chk("R3 idle rd_valid", 32'(rd_valid), 32'h0);

    // R7: same-cycle load uses old value, next cycle new
    @(negedge clk);
    ptr_ld_en = 1'b1; ptr_ld_sel = 3'd3; ptr_ld_data = pv(3);
    acc_valid = 1'b1; acc_write = 1'b0; acc_sel = 3'd3; acc_base = 12'h000;
    #1;
    chk("R7 load cycle old value", 32'(acc_addr), 32'h0);
    acc(1'b0, 3, 12'h000, 16'h0);
    chk("R7 next cycle new value", 32'(acc_addr), 32'(pv(3)));

    for (int s = 0; s < 8; s++) ldp(s, pv(s));

    // R1 sweep, R2 zero base
    for (int s = 0; s < 8; s++) begin
      for (int j = 0; j < 16; j++) begin
        b = 12'((j * 12'h111) ^ (j << 2));
        acc(1'b0, s, b, 16'h0);
        chk("R1 or address", 32'(acc_addr), 32'(b | pv(s)));
      end
      acc(1'b0, s, 12'h000, 16'h0);
      chk("R2 zero base passthrough", 32'(acc_addr), 32'(pv(s)));
    end
    ldp(6, 12'h03C);
    acc(1'b0, 6, 12'h0F0, 16'h0);
    chk("R1 overlapping bits", 32'(acc_addr), 32'h0FC);
    chk("R3 read rd_valid", 32'(rd_valid), 32'h1);
    acc(1'b1, 6, 12'h0F0, 16'h0);
    chk("R3 write rd_valid", 32'(rd_valid), 32'h0);

    // R4: fill eight aligned 64-entry arrays, then read back
    for (int arr = 0; arr < 8; arr++)
      for (int idx = 0; idx < 64; idx++) begin
        ldp(1, 12'(idx));
        acc(1'b1, 1, 12'(arr * 64), dpat(12'(arr * 64 + idx)));
      end
    for (int arr = 0; arr < 8; arr++)
      for (int idx = 0; idx < 64; idx++) begin
        ldp(1, 12'(idx));
        acc(1'b0, 1, 12'(arr * 64), 16'h0);
        chk("R4 array readback", 32'(rd_data), 32'(dpat(12'(arr * 64 + idx))));
      end
    for (int k = 0; k < 8; k++) begin
      ldp(2, 12'(k * 64 + 5));
      acc(1'b0, 2, 12'h000, 16'h0);
      chk("R2 full pointer read", 32'(rd_data), 32'(dpat(12'(k * 64 + 5))));
    end

    // R5 forwarding
    ldp(7, 12'h000);
    a = 12'h0C5; b = 12'h113; c = 12'h1FF;
    acc(1'b1, 7, a, 16'hBEEF);
    acc(1'b0, 7, a, 16'h0);
    chk("R5 forward same addr", 32'(rd_data), 32'hBEEF);
    acc(1'b0, 7, a, 16'h0);
    chk("R4 committed value", 32'(rd_data), 32'hBEEF);
    acc(1'b1, 7, a, 16'h1234);
    acc(1'b0, 7, b, 16'h0);
    chk("R5 other addr after write", 32'(rd_data), 32'(dpat(b)));
    acc(1'b0, 7, a, 16'h0);
    chk("R4 committed overwrite", 32'(rd_data), 32'h1234);

    // R6 back-to-back writes
    acc(1'b1, 7, a, 16'h1111);
    acc(1'b1, 7, b, 16'h2222);
    acc(1'b0, 7, a, 16'h0);
    chk("R6 first of pair", 32'(rd_data), 32'h1111);
    acc(1'b0, 7, b, 16'h0);
    chk("R6 second of pair", 32'(rd_data), 32'h2222);
    acc(1'b1, 7, c, 16'h3333);
    acc(1'b1, 7, c, 16'h4444);
    acc(1'b0, 7, c, 16'h0);
    chk("R6 younger wins forward", 32'(rd_data), 32'h4444);
    acc(1'b0, 7, c, 16'h0);
    chk("R6 younger wins ram", 32'(rd_data), 32'h4444);

    // R8 reset drops pending write
    acc(1'b1, 7, a, 16'h5555);
    @(negedge clk);
    acc_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    for (int s = 0; s < 8; s++) begin
      acc(1'b0, s, 12'h000, 16'h0);
      chk("R8 ptr cleared again", 32'(acc_addr), 32'h0);
    end
    acc(1'b0, 0, a, 16'h0);
    chk("R8 pending write dropped", 32'(rd_data), 32'h1111);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule